// File: doc/BRIEF.md
# Serial Control-Register Slave with Block Write and Block Read-Back

This block is a two-wire serial bus slave (I2C signalling, standard mode) that keeps a small bank of 8-bit control registers. Downstream logic sees every register in parallel on one flat output vector. A host loads the bank with a simplified block write. After the device address come two header bytes, a command byte and a count byte. The slave acknowledges both and then throws them away. Every byte after them goes into the next register, starting at register 0. No register index is ever taken from the bus.

A block read returns a count byte first and then every register in ascending order. The host acknowledges each byte and ends the read with a NACK. Both bus lines are oversampled by the system clock through a synchronizer. Start and stop conditions are recognised from the sampled levels. SDA is driven as an open-drain output: a single enable pulls the line low.

Top module: `i2c_blkreg_slave`

## Requirements
- R1: After reset the bank holds its defaults: register 0 = 0x3C, 1 = 0x00, 2 = 0x0A, 3 = 0xFF, 4 = 0xFF, 5 = 0x65, 6 = 0x87, with register i on regs_o[8i+7:8i]. SDA is released.
- R2: The slave acknowledges an address byte whose upper seven bits are 0x69, sent MSB first: 0xD2 for a write and 0xD3 for a read. It acknowledges by pulling SDA low for the ninth clock.
- R3: The slave does not acknowledge any other address byte, and the bytes of that transaction leave every register unchanged.
- R4: In a write, the first two bytes after the address are acknowledged and discarded. Each following byte is stored in registers 0, 1, 2 and upward, in that order.
- R5: A stop after any complete byte ends the write. Registers already written keep their new values, and the rest keep their old ones.
- R6: A byte cut short by a stop, with fewer than eight bits clocked, is discarded.
- R7: Data bytes beyond the last register are acknowledged and dropped. They do not change any register.
- R8: A read returns the count byte 7 (the number of registers) and then registers 0 to 6, each MSB first.
- R9: A NACK from the host ends a read. The slave releases SDA and drives nothing until the next start.
- R10: The slave changes SDA only while SCL is low, so the level it drives stays stable during each SCL high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, sampled asynchronously |
| sda_i | input | 1 | Bus data line level, sampled asynchronously |
| sda_oe_o | output | 1 | When high, pulls the SDA line low (open-drain) |
| regs_o | output | 56 | All registers in parallel, register i at bits 8i+7:8i |

## Verification
The write path is tried with four patterns: a full-length burst, a burst cut off after two data bytes, a burst whose last byte stops after four bits, and a burst that runs two bytes past the end of the bank. Together they separate correct header skipping and ascending fill from off-by-one indexing, from commits made only at stop, and from writes that wrap or overflow. Addresses that differ from the device address in a single bit check that the match is exact. Two read patterns are used: a full read ending in NACK, and a read cut short by an early NACK. These check the count byte, the byte order and bit order, the release of SDA after NACK, and that SDA stays stable while SCL is high.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } st_e;
endpackage

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  // start: data falls while clock stays high; stop: data rises while clock stays high
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/i2cb_bank.sv
module i2cb_bank #(
  parameter int NREG = 7,
  parameter int IW = 4,
  parameter logic [NREG*8-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [7:0]      wr_data,
  input  logic [IW-1:0]   rd_idx,
  output logic [7:0]      rd_data,
  output logic [NREG*8-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= RST_VAL[8*g +: 8];
      else if (wr_en && wr_idx == IW'(g)) q <= wr_data;
    end
    assign regs_o[8*g +: 8] = q;

    // R4: a write strobe aimed at this register lands on the next edge
    a_r4_store: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_idx == IW'(g)) |=> (regs_o[8*g +: 8] == $past(wr_data)));
  end

  // index 0 yields the count byte, 1..NREG the registers, anything later reads as released bus
  always_comb begin
    rd_data = 8'hFF;
    if (rd_idx == '0) rd_data = 8'(NREG);
    for (int i = 0; i < NREG; i++)
      if (rd_idx == IW'(i + 1)) rd_data = regs_o[8*i +: 8];
  end

  a_r1_defaults: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (regs_o == RST_VAL));
endmodule

// File: rtl/i2cb_ctrl.sv
module i2cb_ctrl
  import i2cb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NREG = 7,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_lvl,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rd_data,
  output logic [IW-1:0] rd_idx,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic          sda_oe
);
  localparam logic [IW-1:0] HDR_BYTES = IW'(2);
  localparam logic [IW-1:0] W_LIMIT   = IW'(NREG + 2);
  localparam logic [IW-1:0] R_LIMIT   = IW'(NREG + 1);

  st_e          st;
  logic [3:0]   cnt;
  logic [7:0]   sh, tx;
  logic         rw, nack;
  logic [IW-1:0] widx, ridx;

  assign rd_idx = ridx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx      <= '0;
      rw      <= 1'b0;
      nack    <= 1'b0;
      widx    <= '0;
      ridx    <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_WDATA: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_lvl};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (sh[7:1] == DEV_ADDR) begin
                  rw     <= sh[0];
                  widx   <= '0;
                  ridx   <= '0;
                  sda_oe <= 1'b1;
                  st     <= ST_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                st     <= ST_ACK;
                if (widx >= HDR_BYTES && widx < W_LIMIT) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= widx - HDR_BYTES;
                  wr_data <= sh;
                end
                if (widx < W_LIMIT) widx <= widx + IW'(1);
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[7];
                st     <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= ST_RACK;
              end else begin
                cnt    <= cnt + 4'd1;
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              nack <= sda_lvl;
              if (!sda_lvl && ridx < R_LIMIT) ridx <= ridx + IW'(1);
            end else if (scl_fall) begin
              cnt <= '0;
              if (nack) begin
                st <= ST_IDLE;
              end else begin
                tx     <= rd_data;
                sda_oe <= ~rd_data[7];
                st     <= ST_RDATA;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: the pull-down only engages after the clock was seen low
  a_r10_drive_on_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_lvl));

  // R9: an idle slave never holds the line
  a_r9_idle_released: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> (st != ST_IDLE));

  // R9: a sampled NACK returns the controller to idle with the line free
  a_r9_nack_ends: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RACK && nack && scl_fall && !start_det && !stop_det)
      |=> (st == ST_IDLE && !sda_oe));

  // R3: a foreign address gets no acknowledge
  a_r3_mismatch_no_ack: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ADDR && scl_fall && cnt == 4'd8 && !start_det && !stop_det
     && sh[7:1] != DEV_ADDR) |=> (!sda_oe && st == ST_IDLE));

  // R7: overflow bytes never produce a write strobe
  a_r7_write_in_range: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx < IW'(NREG)));
endmodule

// File: rtl/i2c_blkreg_slave.sv
module i2c_blkreg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NREG = 7,
  parameter int SYNC_STAGES = 2,
  parameter logic [NREG*8-1:0] RST_VAL = 56'h87_65_FF_FF_0A_00_3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] regs_o
);
  localparam int IW = $clog2(NREG + 3);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [7:0] wr_data, rd_data;

  i2cb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2cb_ctrl #(.DEV_ADDR(DEV_ADDR), .NREG(NREG), .IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_data(rd_data), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .sda_oe(sda_oe_o)
  );

  i2cb_bank #(.NREG(NREG), .IW(IW), .RST_VAL(RST_VAL)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .regs_o(regs_o)
  );
endmodule

// File: tb/i2c_blkreg_slave_test.sv
`timescale 1ns/1ps
module i2c_blkreg_slave_test;
  localparam int NREG = 7;
  localparam time Q = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic hsda = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  wire sda_line = hsda & ~sda_oe;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_r [NREG];

  always #10 clk = ~clk;

  i2c_blkreg_slave uut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [NREG*8-1:0] exp_flat();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[8*i +: 8] = exp_r[i];
    return v;
  endfunction

  task automatic bus_start();
    hsda = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    hsda = 1'b0; #Q; scl = 1'b1; #Q; hsda = 1'b1; #(2*Q);
  endtask

  task automatic send_bit(input logic b);
    hsda = b; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    hsda = 1'b1; #Q; scl = 1'b1; #Q;
    ack = !sda_line;
    #Q; scl = 1'b0; #Q;
  endtask

  task automatic rd_byte(input logic host_ack, output logic [7:0] b, output logic stable);
    logic s1, s2;
    stable = 1'b1;
    b = '0;
    hsda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      #Q; scl = 1'b1; #Q; s1 = sda_line; #Q; s2 = sda_line;
      if (s1 !== s2) stable = 1'b0;
      b = {b[6:0], s1};
      scl = 1'b0;
    end
    send_bit(!host_ack);
    hsda = 1'b1;
  endtask

  task automatic wr_header(input logic [7:0] addr, output logic all_ack);
    logic a;
    all_ack = 1'b1;
    wr_byte(addr, a);  all_ack &= a;
    wr_byte(8'hAA, a); all_ack &= a;   // command byte, discarded
    wr_byte(8'h07, a); all_ack &= a;   // count byte, discarded
  endtask

  task automatic test_reset();
    chk("R1", "register defaults", 64'(regs), 64'(exp_flat()));
    chk("R1", "sda released", 64'(sda_oe), 64'd0);
  endtask

  task automatic test_full_write();
    logic a, all;
    logic [7:0] d [NREG];
    d = '{8'hA1, 8'h52, 8'hC3, 8'h14, 8'hE5, 8'h36, 8'h97};
    bus_start();
    wr_byte(8'hD2, a);
    chk("R2", "write address ack", 64'(a), 64'd1);
    wr_byte(8'h5C, a); all = a;
    wr_byte(8'h03, a); all &= a;
    chk("R4", "header bytes acked", 64'(all), 64'd1);
    all = 1'b1;
    for (int i = 0; i < NREG; i++) begin
      wr_byte(d[i], a); all &= a; exp_r[i] = d[i];
    end
    bus_stop();
    chk("R4", "data bytes acked", 64'(all), 64'd1);
    chk("R4", "registers filled from 0", 64'(regs), 64'(exp_flat()));
  endtask

  task automatic test_wrong_addr(input logic [7:0] addr);
    logic a;
    bus_start();
    wr_byte(addr, a);
    chk("R3", "foreign address not acked", 64'(a), 64'd0);
    wr_byte(8'h00, a);
    wr_byte(8'h00, a);
    wr_byte(8'h5A, a);
    wr_byte(8'h5A, a);
    bus_stop();
    chk("R3", "registers unchanged", 64'(regs), 64'(exp_flat()));
  endtask

  task automatic test_partial_write();
    logic a, all;
    bus_start();
    wr_header(8'hD2, all);
    wr_byte(8'h5A, a); all &= a; exp_r[0] = 8'h5A;
    wr_byte(8'h6B, a); all &= a; exp_r[1] = 8'h6B;
    bus_stop();
    chk("R5", "partial write acks", 64'(all), 64'd1);
    chk("R5", "only leading registers updated", 64'(regs), 64'(exp_flat()));
  endtask

  task automatic test_cut_byte();
    logic a, all;
    bus_start();
    wr_header(8'hD2, all);
    wr_byte(8'h77, a); exp_r[0] = 8'h77;
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    chk("R6", "truncated byte discarded", 64'(regs), 64'(exp_flat()));
  endtask

  task automatic test_overflow();
    logic a, all;
    bus_start();
    wr_header(8'hD2, all);
    for (int i = 0; i < NREG + 2; i++) begin
      wr_byte(8'(8'h20 + 8'(i * 17)), a); all &= a;
      if (i < NREG) exp_r[i] = 8'(8'h20 + 8'(i * 17));
    end
    bus_stop();
    chk("R7", "bytes past the bank acked", 64'(all), 64'd1);
    chk("R7", "extra bytes dropped", 64'(regs), 64'(exp_flat()));
  endtask

  task automatic test_full_read();
    logic a, st, all_st;
    logic [7:0] b;
    bus_start();
    wr_byte(8'hD3, a);
    chk("R2", "read address ack", 64'(a), 64'd1);
    rd_byte(1'b1, b, all_st);
    chk("R8", "count byte", 64'(b), 64'd7);
    for (int i = 0; i < NREG; i++) begin
      rd_byte(i != NREG - 1, b, st); all_st &= st;
      chk("R8", $sformatf("read register %0d", i), 64'(b), 64'(exp_r[i]));
    end
    chk("R10", "sda stable while scl high", 64'(all_st), 64'd1);
    #(2*Q);
    chk("R9", "released after nack", 64'(sda_oe), 64'd0);
    bus_stop();
  endtask

  task automatic test_early_nack();
    logic a, st;
    logic [7:0] b;
    bus_start();
    wr_byte(8'hD3, a);
    rd_byte(1'b1, b, st);
    rd_byte(1'b0, b, st);
    chk("R8", "first register after count", 64'(b), 64'(exp_r[0]));
    rd_byte(1'b0, b, st);
    chk("R9", "nothing driven after nack", 64'(b), 64'hFF);
    bus_stop();
  endtask

  initial begin
    exp_r = '{8'h3C, 8'h00, 8'h0A, 8'hFF, 8'hFF, 8'h65, 8'h87};
    #5;
    #(20 * 20);
    rst = 1'b0;
    #(10 * 20);
    test_reset();
    test_full_write();
    test_wrong_addr(8'hD0);
    test_wrong_addr(8'hD6);
    test_partial_write();
    test_cut_byte();
    test_overflow();
    test_full_read();
    test_early_nack();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #3_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule